// File: doc/BRIEF.md
# True dual-port RAM with per-port write modes

A synchronous memory array shared by two completely independent ports, A and B. Each port has its own clock, enable, write enable, address, write data and read data. On every edge of its own clock a port may read or write, and it may switch between the two from one cycle to the next. Both ports may write in the same period. Port A and port B share nothing except the stored words.

Each port has a parameter that selects what its output register shows after a write. In write-first mode it shows the written data. In read-first mode it shows the word that the write replaced. In no-change mode it keeps its earlier value. The output is always driven. The storage is built from two arrays, one written by each clock domain. The stored word is the XOR of the two arrays, so neither array has two writers. Both ports may write one address on coincident edges. In that case the stored word is undefined, and users must avoid it. The stored words are not reset and start at zero. The output registers clear on the active-low asynchronous reset.

Top module: `tdp_ram`

## Requirements
- R1: With enable high and write enable low on a port, that port's output shows the word at its address one edge of its own clock later.
- R2: A word written through either port is returned by a later read of that address through either port.
- R3: A port set to write-first shows, one edge after a write, the data just written.
- R4: A port set to read-first shows, one edge after a write, the word held at that address before the write.
- R5: A port set to no-change keeps, after a write, the output value it had before that write.
- R6: With enable low, a port writes nothing, whatever its write enable and data are, and its output holds.
- R7: On a read cycle the write data input has no effect on the stored words.
- R8: Both ports writing different addresses in the same period store both words.
- R9: While the reset is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the output registers |
| en_a_i | input | 1 | Port A enable |
| we_a_i | input | 1 | Port A write enable |
| addr_a_i | input | $clog2(DEPTH) | Port A word address |
| din_a_i | input | WIDTH | Port A write data |
| dout_a_o | output | WIDTH | Port A output register |
| en_b_i | input | 1 | Port B enable |
| we_b_i | input | 1 | Port B write enable |
| addr_b_i | input | $clog2(DEPTH) | Port B word address |
| din_b_i | input | WIDTH | Port B write data |
| dout_b_o | output | WIDTH | Port B output register |

## Verification
Any corrupted word in either storage array changes the XOR result. The next read of that address through either port therefore shows it on the output one edge later. A wrong write-mode choice shows on the output in the edge right after the write. A write done while the port is disabled shows up only when that address is read later, so the bench reads back every such address. Three instances together cover each mode on each port against one reference model. Clock edges of A and B never coincide in the bench, so every cross-port ordering is well defined.

// File: rtl/tdp_ram_pkg.sv
package tdp_ram_pkg;
  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;
endpackage

// File: rtl/tdp_ram_bank.sv
// One storage array, written from a single clock domain, read at both port addresses.
module tdp_ram_bank #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                  clk_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         waddr_i,
  input  logic [WIDTH-1:0]      wdata_i,
  input  logic [1:0][AW-1:0]    raddr_i,
  output logic [1:0][WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH] = '{default: '0};

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar r = 0; r < 2; r++) begin : g_rd
    assign rdata_o[r] = mem_q[raddr_i[r]];
  end
endmodule

// File: rtl/tdp_ram_port.sv
// Output register of one port with its write-mode selection.
module tdp_ram_port #(
  parameter int                  WIDTH = 16,
  parameter tdp_ram_pkg::wmode_e MODE  = tdp_ram_pkg::WM_WRITE_FIRST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] dout_o
);
  import tdp_ram_pkg::*;

  logic [WIDTH-1:0] dout_q, dout_d;

  always_comb begin
    dout_d = dout_q;
    if (en_i) begin
      if (!we_i) begin
        dout_d = word_i;
      end else begin
        unique case (MODE)
          WM_WRITE_FIRST: dout_d = din_i;
          WM_READ_FIRST:  dout_d = word_i;
          default:        dout_d = dout_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dout_q <= '0;
    else         dout_q <= dout_d;
  end

  assign dout_o = dout_q;

  assert_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !we_i) |=> (dout_o == $past(word_i)));

  assert_disabled_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(dout_o));

  if (MODE == WM_WRITE_FIRST) begin : g_wf
    assert_write_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && we_i) |=> (dout_o == $past(din_i)));
  end else if (MODE == WM_READ_FIRST) begin : g_rf
    assert_read_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && we_i) |=> (dout_o == $past(word_i)));
  end else begin : g_nc
    assert_no_change_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && we_i) |=> $stable(dout_o));
  end
endmodule

// File: rtl/tdp_ram.sv
// True dual-port RAM; stored word = bank0 ^ bank1, each bank owned by one port clock.
module tdp_ram #(
  parameter int                  WIDTH  = 16,
  parameter int                  DEPTH  = 256,
  parameter tdp_ram_pkg::wmode_e MODE_A = tdp_ram_pkg::WM_WRITE_FIRST,
  parameter tdp_ram_pkg::wmode_e MODE_B = tdp_ram_pkg::WM_WRITE_FIRST,
  localparam int                 AW     = $clog2(DEPTH)
) (
  input  logic             clk_a_i,
  input  logic             clk_b_i,
  input  logic             rst_ni,
  input  logic             en_a_i,
  input  logic             we_a_i,
  input  logic [AW-1:0]    addr_a_i,
  input  logic [WIDTH-1:0] din_a_i,
  output logic [WIDTH-1:0] dout_a_o,
  input  logic             en_b_i,
  input  logic             we_b_i,
  input  logic [AW-1:0]    addr_b_i,
  input  logic [WIDTH-1:0] din_b_i,
  output logic [WIDTH-1:0] dout_b_o
);
  logic [1:0]                  clk, en, we;
  logic [1:0][AW-1:0]          addr;
  logic [1:0][WIDTH-1:0]       din, dout, word;
  logic [1:0][1:0][WIDTH-1:0]  rd;  // rd[bank][port]

  assign clk  = {clk_b_i, clk_a_i};
  assign en   = {en_b_i, en_a_i};
  assign we   = {we_b_i, we_a_i};
  assign addr = {addr_b_i, addr_a_i};
  assign din  = {din_b_i, din_a_i};

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [WIDTH-1:0] wdata;
    // Cancel the other bank so the XOR of both yields din.
    assign wdata   = din[p] ^ rd[1-p][p];
    assign word[p] = rd[0][p] ^ rd[1][p];

    tdp_ram_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_bank (
      .clk_i   (clk[p]),
      .we_i    (en[p] & we[p]),
      .waddr_i (addr[p]),
      .wdata_i (wdata),
      .raddr_i (addr),
      .rdata_o (rd[p])
    );

    tdp_ram_port #(.WIDTH(WIDTH), .MODE(p == 0 ? MODE_A : MODE_B)) u_port (
      .clk_i  (clk[p]),
      .rst_ni (rst_ni),
      .en_i   (en[p]),
      .we_i   (we[p]),
      .din_i  (din[p]),
      .word_i (word[p]),
      .dout_o (dout[p])
    );
  end

  assign dout_a_o = dout[0];
  assign dout_b_o = dout[1];
endmodule

// File: tb/tdp_ram_bench.sv
`timescale 1ns/1ps
module tdp_ram_bench;
  import tdp_ram_pkg::*;
  localparam int W = 16;
  localparam int D = 16;
  localparam int AW = 4;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic en_a = 0, we_a = 0, en_b = 0, we_b = 0;
  logic [AW-1:0] addr_a = '0, addr_b = '0;
  logic [W-1:0] din_a = '0, din_b = '0;
  logic [W-1:0] dout_a [3];
  logic [W-1:0] dout_b [3];

  int checks = 0, errors = 0, collisions = 0;
  bit done = 0;

  always #2.5 clk_a = ~clk_a;          // 200 MHz
  initial begin #1.3; forever #3.5 clk_b = ~clk_b; end  // edges never meet clk_a

  // Port A instance i runs mode i; port B instance i runs mode (i+1)%3.
  tdp_ram #(.WIDTH(W), .DEPTH(D), .MODE_A(WM_WRITE_FIRST), .MODE_B(WM_READ_FIRST)) u_tdp_ram (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .en_a_i(en_a), .we_a_i(we_a), .addr_a_i(addr_a), .din_a_i(din_a), .dout_a_o(dout_a[0]),
    .en_b_i(en_b), .we_b_i(we_b), .addr_b_i(addr_b), .din_b_i(din_b), .dout_b_o(dout_b[0]));
  tdp_ram #(.WIDTH(W), .DEPTH(D), .MODE_A(WM_READ_FIRST), .MODE_B(WM_NO_CHANGE)) u_tdp_ram_1 (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .en_a_i(en_a), .we_a_i(we_a), .addr_a_i(addr_a), .din_a_i(din_a), .dout_a_o(dout_a[1]),
    .en_b_i(en_b), .we_b_i(we_b), .addr_b_i(addr_b), .din_b_i(din_b), .dout_b_o(dout_b[1]));
  tdp_ram #(.WIDTH(W), .DEPTH(D), .MODE_A(WM_NO_CHANGE), .MODE_B(WM_WRITE_FIRST)) u_tdp_ram_2 (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .en_a_i(en_a), .we_a_i(we_a), .addr_a_i(addr_a), .din_a_i(din_a), .dout_a_o(dout_a[2]),
    .en_b_i(en_b), .we_b_i(we_b), .addr_b_i(addr_b), .din_b_i(din_b), .dout_b_o(dout_b[2]));

  // Reference model; exp index = mode (0 write-first, 1 read-first, 2 no-change).
  logic [W-1:0] mem_m [D] = '{default: '0};
  bit           bad_m [D] = '{default: 1'b0};
  realtime      t_wa [D] = '{default: -1.0};
  realtime      t_wb [D] = '{default: -1.0};
  logic [W-1:0] exp_a [3] = '{default: '0};
  logic [W-1:0] exp_b [3] = '{default: '0};
  bit ok_a = 1, ok_b = 1;

  function automatic string mode_tag(int m);
    return (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
  endfunction

  always @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) exp_a = '{default: '0};
    else if (en_a) begin
      ok_a = !bad_m[addr_a];
      if (we_a) begin
        if (t_wb[addr_a] == $realtime) begin bad_m[addr_a] = 1; collisions++; end
        exp_a[1] = mem_m[addr_a];
        exp_a[0] = din_a;
        mem_m[addr_a] = din_a;
        t_wa[addr_a] = $realtime;
      end else begin
        exp_a = '{default: mem_m[addr_a]};
      end
    end
  end

  always @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) exp_b = '{default: '0};
    else if (en_b) begin
      ok_b = !bad_m[addr_b];
      if (we_b) begin
        if (t_wa[addr_b] == $realtime) begin bad_m[addr_b] = 1; collisions++; end
        exp_b[1] = mem_m[addr_b];
        exp_b[0] = din_b;
        mem_m[addr_b] = din_b;
        t_wb[addr_b] = $realtime;
      end else begin
        exp_b = '{default: mem_m[addr_b]};
      end
    end
  end

  task automatic check(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic op_a(bit en, bit we, int addr, logic [W-1:0] d, string rtag);
    en_a = en; we_a = we; addr_a = AW'(addr); din_a = d;
    @(posedge clk_a); @(negedge clk_a);
    if (ok_a)
      for (int i = 0; i < 3; i++)
        check((en && we) ? mode_tag(i) : rtag, $sformatf("port A inst %0d", i), dout_a[i], exp_a[i]);
  endtask

  task automatic op_b(bit en, bit we, int addr, logic [W-1:0] d, string rtag);
    en_b = en; we_b = we; addr_b = AW'(addr); din_b = d;
    @(posedge clk_b); @(negedge clk_b);
    if (ok_b)
      for (int i = 0; i < 3; i++)
        check((en && we) ? mode_tag((i + 1) % 3) : rtag, $sformatf("port B inst %0d", i),
              dout_b[i], exp_b[(i + 1) % 3]);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #20.2;
    for (int i = 0; i < 3; i++) begin
      check("R9", "port A reset", dout_a[i], '0);
      check("R9", "port B reset", dout_b[i], '0);
    end
    rst_n = 1'b1;
    @(negedge clk_a);
    // R8: both ports fill disjoint halves concurrently
    fork
      for (int k = 0; k < 8; k++) op_a(1, 1, k, W'(16'h1100 + k), "R8");
      begin @(negedge clk_b); for (int k = 8; k < 16; k++) op_b(1, 1, k, W'(16'hb800 + k), "R8"); end
    join
    @(negedge clk_a);
    // R2: cross-port read back of every word
    fork
      for (int k = 8; k < 16; k++) op_a(1, 0, k, '0, "R2");
      begin @(negedge clk_b); for (int k = 0; k < 8; k++) op_b(1, 0, k, '0, "R2"); end
    join
    @(negedge clk_a);
    // R3/R4/R5 overwrite of a known word, then read
    op_a(1, 1, 5, 16'hcafe, "R3");
    op_a(1, 0, 5, 16'h0000, "R1");
    // R6: disabled write attempt, output must hold, word unchanged
    op_a(1, 0, 3, '0, "R1");
    op_a(0, 1, 3, 16'hdead, "R6");
    op_a(0, 0, 9, 16'hbeef, "R6");
    op_a(1, 0, 3, '0, "R6");
    // R7: junk on din during read
    op_a(1, 0, 6, 16'h5a5a, "R7");
    @(negedge clk_b);
    op_b(1, 0, 6, 16'ha5a5, "R7");
    op_b(0, 1, 6, 16'h7777, "R6");
    op_b(1, 0, 6, 16'h7777, "R7");
    // R2: B writes, then A reads same address
    op_b(1, 1, 2, 16'h2222, "R2");
    @(negedge clk_a);
    op_a(1, 0, 2, '0, "R2");
    op_a(1, 1, 2, 16'h3333, "R4");
    @(negedge clk_b);
    op_b(1, 0, 2, '0, "R2");
    // Random traffic on both ports concurrently
    @(negedge clk_a);
    fork
      for (int k = 0; k < 600; k++)
        op_a(($urandom % 10) != 0, $urandom % 2, $urandom % D, W'($urandom), "R1");
      begin
        @(negedge clk_b);
        for (int k = 0; k < 450; k++)
          op_b(($urandom % 10) != 0, $urandom % 2, $urandom % D, W'($urandom), "R1");
      end
    join
    if (collisions != 0) $display("note: %0d same-edge collisions skipped", collisions);
    finish_run();
  end
endmodule